// File: doc/BRIEF.md
# Trap-Level-Banked Privileged Control Register File

This block holds the privileged control and status state of one processor strand. It has one access port, selected by a 5-bit register index. A read is combinational from the index. A write commits on the next rising clock edge. Most registers are single words. Five of them are banked by trap level: trap PC, trap next-PC, trap state, trap type and hyper trap state. An access to any of these five uses the bank entry at (current trap level − 1), so a trap handler sees only the context saved for its own level.

Some writes are shaped on the way in. The processor-state word keeps only its defined fields. The trap base address keeps only 32 KiB alignment. The trap level stops at the configured maximum. A read-only version word reports the window count, the maximum trap level and the maximum global level. The block flags an error when an index is unused, when a banked register is accessed at trap level zero, or when the version word is written. A flagged access has no effect on any state.

Top module: `ctlreg_file`

## Requirements
- R1: After reset, the tick word reads 0x8000_0000_0000_0000, the hyper-privileged state reads 0x800 and strand status reads 0x50000. Every other register reads zero, including every bank entry at every trap level.
- R2: A write to processor state (index 0x05) stores the data ANDed with 0x13DE, which keeps bits 4:1, 9:6 and 12 and stores every other bit as zero.
- R3: A write to trap base (index 0x07) stores the data with bits 14:0 forced to zero.
- R4: The version word (index 0x0B) reads {40'b0, MAX_GL[7:0], MAX_TL[7:0], NUM_WIN[7:0]}. A write to it raises `acc_err` and changes nothing.
- R5: The banked registers are trap PC 0x00, next-PC 0x01, trap state 0x02, trap type 0x03 and hyper trap state 0x04. A read or write of one of them uses the entry at level (trap level − 1). The entries at other levels are unchanged.
- R6: While the trap level is zero, an access to a banked index raises `acc_err` and reads zero, and a write is discarded.
- R7: A write to trap level (index 0x06) stores min(data, MAX_TL).
- R8: Scratchpad words at indices 0x10..0x17 are eight independent read/write 64-bit registers.
- R9: Indices 0x0C..0x0F and 0x18..0x1F are unused. An access to one raises `acc_err`, reads zero and changes no state.
- R10: `acc_err` is low whenever `acc_en` is low. A write takes effect only at the rising edge where `acc_en` and `acc_we` are both high. `rd_data` shows the value stored before that edge.
- R11: The remaining indices are hyper-privileged state 0x08, strand status 0x09 and tick 0x0A. Each is a plain 64-bit read/write register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access strobe |
| acc_we | input | 1 | Write when high, read when low (qualified by acc_en) |
| acc_idx | input | 5 | Register index |
| acc_wdata | input | 64 | Write data |
| rd_data | output | 64 | Combinational read data for acc_idx |
| acc_err | output | 1 | Access error flag, combinational |

## Verification
Random operations over all 32 indices are run against a bench model, with trap-level writes drawn from a small range that includes zero and values above the maximum. This mixes banked accesses at every level, at level zero and after saturation, and it tells a wrong bank index apart from a correct one. Directed sequences then cover the following cases:
- The same banked register is written at two levels and read back at the first level, to expose bank aliasing.
- All-ones data is written to processor state and trap base, to expose a wrong mask.
- Distinct scratchpad values are read back, to expose crossed scratchpad decode.
- Writes go to the version word, to unused indices and to banked indices at level zero, followed by read-back, to show that a flagged access leaves state untouched.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

    localparam int IDX_W   = 5;
    localparam int DATA_W  = 64;
    localparam int NUM_STK = 5;
    localparam int NUM_SCR = 8;

    localparam logic [IDX_W-1:0] IX_STK_LAST = 5'h04;
    localparam logic [IDX_W-1:0] IX_PSTATE   = 5'h05;
    localparam logic [IDX_W-1:0] IX_TLEVEL   = 5'h06;
    localparam logic [IDX_W-1:0] IX_TBASE    = 5'h07;
    localparam logic [IDX_W-1:0] IX_HPRIV    = 5'h08;
    localparam logic [IDX_W-1:0] IX_STRAND   = 5'h09;
    localparam logic [IDX_W-1:0] IX_TICK     = 5'h0A;
    localparam logic [IDX_W-1:0] IX_VERSION  = 5'h0B;

    localparam logic [DATA_W-1:0] PSTATE_KEEP = 64'h0000_0000_0000_13DE;
    localparam logic [DATA_W-1:0] TBASE_KEEP  = ~64'h0000_0000_0000_7FFF;
    localparam logic [DATA_W-1:0] HPRIV_RST   = 64'h0000_0000_0000_0800;
    localparam logic [DATA_W-1:0] STRAND_RST  = 64'h0000_0000_0005_0000;
    localparam logic [DATA_W-1:0] TICK_RST    = 64'h8000_0000_0000_0000;

    typedef enum logic [3:0] {
        K_NONE, K_STACK, K_PSTATE, K_TLEVEL, K_TBASE,
        K_HPRIV, K_STRAND, K_TICK, K_VERSION, K_SCR
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic [2:0] sub;
    } dec_t;

endpackage

// File: rtl/ctlreg_decode.sv
module ctlreg_decode
    import ctlreg_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output dec_t             dec
);

    always_comb begin
        dec.sub  = idx[2:0];
        dec.kind = K_NONE;
        if (idx <= IX_STK_LAST) begin
            dec.kind = K_STACK;
        end else if (idx[4:3] == 2'b10) begin
            dec.kind = K_SCR;
        end else begin
            case (idx)
                IX_PSTATE:  dec.kind = K_PSTATE;
                IX_TLEVEL:  dec.kind = K_TLEVEL;
                IX_TBASE:   dec.kind = K_TBASE;
                IX_HPRIV:   dec.kind = K_HPRIV;
                IX_STRAND:  dec.kind = K_STRAND;
                IX_TICK:    dec.kind = K_TICK;
                IX_VERSION: dec.kind = K_VERSION;
                default:    dec.kind = K_NONE;
            endcase
        end
    end

endmodule

// File: rtl/ctlreg_trap_stack.sv
module ctlreg_trap_stack
    import ctlreg_pkg::*;
#(
    parameter int MAX_TL = 6,
    localparam int LVW   = (MAX_TL > 1) ? $clog2(MAX_TL) : 1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        sel,
    input  logic [LVW-1:0]    lvl,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data
);

    logic [NUM_STK-1:0][DATA_W-1:0] ent [MAX_TL];

    for (genvar l = 0; l < MAX_TL; l++) begin : g_level
        logic [NUM_STK-1:0][DATA_W-1:0] lvl_d, lvl_q;

        always_comb begin
            lvl_d = lvl_q;
            if (wr_en && (lvl == LVW'(l)) && (32'(sel) < NUM_STK)) begin
                lvl_d[sel] = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q <= '0;
            else        lvl_q <= lvl_d;
        end

        assign ent[l] = lvl_q;
    end

    always_comb begin
        rd_data = '0;
        for (int l = 0; l < MAX_TL; l++) begin
            if (lvl == LVW'(l)) begin
                for (int r = 0; r < NUM_STK; r++) begin
                    if (sel == 3'(r)) rd_data = ent[l][r];
                end
            end
        end
    end

endmodule

// File: rtl/ctlreg_file.sv
module ctlreg_file
    import ctlreg_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int MAX_TL  = 6,
    parameter int MAX_GL  = 3
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [4:0]        acc_idx,
    input  logic [63:0]       acc_wdata,
    output logic [63:0]       rd_data,
    output logic              acc_err
);

    localparam int TLW = $clog2(MAX_TL + 1);
    localparam int LVW = (MAX_TL > 1) ? $clog2(MAX_TL) : 1;
    localparam logic [DATA_W-1:0] VER_WORD =
        {40'd0, 8'(MAX_GL), 8'(MAX_TL), 8'(NUM_WIN)};

    typedef struct packed {
        logic [DATA_W-1:0]              pstate;
        logic [DATA_W-1:0]              tbase;
        logic [DATA_W-1:0]              hpriv;
        logic [DATA_W-1:0]              strand;
        logic [DATA_W-1:0]              tick;
        logic [TLW-1:0]                 tlevel;
        logic [NUM_SCR-1:0][DATA_W-1:0] scr;
    } state_t;

    state_t st_d, st_q;
    dec_t   dec;

    logic              tl_zero;
    logic              bad_acc;
    logic              wr_ok;
    logic              stk_wr;
    logic [LVW-1:0]    cur_lvl;
    logic [DATA_W-1:0] stk_rd;

    ctlreg_decode u_dec (
        .idx (acc_idx),
        .dec (dec)
    );

    assign tl_zero = (st_q.tlevel == '0);
    assign cur_lvl = LVW'(st_q.tlevel - TLW'(1));

    always_comb begin
        bad_acc = (dec.kind == K_NONE)
                | ((dec.kind == K_STACK) && tl_zero)
                | ((dec.kind == K_VERSION) && acc_we);
        acc_err = acc_en && bad_acc;
        wr_ok   = acc_en && acc_we && !bad_acc;
        stk_wr  = wr_ok && (dec.kind == K_STACK);
    end

    ctlreg_trap_stack #(.MAX_TL(MAX_TL)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (stk_wr),
        .sel     (dec.sub),
        .lvl     (cur_lvl),
        .wdata   (acc_wdata),
        .rd_data (stk_rd)
    );

    always_comb begin
        st_d = st_q;
        if (wr_ok) begin
            case (dec.kind)
                K_PSTATE: st_d.pstate = acc_wdata & PSTATE_KEEP;
                K_TBASE:  st_d.tbase  = acc_wdata & TBASE_KEEP;
                K_HPRIV:  st_d.hpriv  = acc_wdata;
                K_STRAND: st_d.strand = acc_wdata;
                K_TICK:   st_d.tick   = acc_wdata;
                K_SCR:    st_d.scr[dec.sub] = acc_wdata;
                K_TLEVEL: begin
                    if (acc_wdata > 64'(MAX_TL)) st_d.tlevel = TLW'(MAX_TL);
                    else                         st_d.tlevel = acc_wdata[TLW-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.hpriv  <= HPRIV_RST;
            st_q.strand <= STRAND_RST;
            st_q.tick   <= TICK_RST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (dec.kind)
            K_STACK:   rd_data = tl_zero ? '0 : stk_rd;
            K_PSTATE:  rd_data = st_q.pstate;
            K_TLEVEL:  rd_data = 64'(st_q.tlevel);
            K_TBASE:   rd_data = st_q.tbase;
            K_HPRIV:   rd_data = st_q.hpriv;
            K_STRAND:  rd_data = st_q.strand;
            K_TICK:    rd_data = st_q.tick;
            K_VERSION: rd_data = VER_WORD;
            K_SCR:     rd_data = st_q.scr[dec.sub];
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/ctlreg_file_chk.sv
module ctlreg_file_chk #(
    parameter int MAX_TL = 6,
    parameter int TLW    = 3
)(
    input logic        clk,
    input logic        rst_n,
    input logic        acc_en,
    input logic        acc_we,
    input logic [4:0]  acc_idx,
    input logic [63:0] rd_data,
    input logic        acc_err,
    input logic [63:0] pstate_q,
    input logic [63:0] tbase_q,
    input logic [TLW-1:0] tlevel_q
);

    logic unused_idx;
    assign unused_idx = (acc_idx[4:2] == 3'b011) || (acc_idx[4:3] == 2'b11);

    AST_PSTATE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate_q & ~64'h13DE) == 64'd0);                              // R2
    AST_TBASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        tbase_q[14:0] == 15'd0);                                       // R3
    AST_TL_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        32'(tlevel_q) <= MAX_TL);                                      // R7
    AST_VERSION_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_we && acc_idx == 5'h0B) |-> acc_err);           // R4
    AST_TL0_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_idx <= 5'h04 && tlevel_q == '0) |-> (acc_err && rd_data == 64'd0)); // R6
    AST_UNUSED_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && unused_idx) |-> (acc_err && rd_data == 64'd0));     // R9
    AST_ERR_KEEPS_TL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_err) |=> $stable(tlevel_q));                    // R9
    AST_ERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |-> !acc_err);                                         // R10

endmodule

bind ctlreg_file ctlreg_file_chk #(.MAX_TL(MAX_TL), .TLW(TLW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_en   (acc_en),
    .acc_we   (acc_we),
    .acc_idx  (acc_idx),
    .rd_data  (rd_data),
    .acc_err  (acc_err),
    .pstate_q (st_q.pstate),
    .tbase_q  (st_q.tbase),
    .tlevel_q (st_q.tlevel)
);

// File: tb/ctlreg_file_tb.sv
module ctlreg_file_tb;

    localparam int NUM_WIN = 8;
    localparam int MAX_TL  = 6;
    localparam int MAX_GL  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_we = 1'b0;
    logic [4:0]  acc_idx = '0;
    logic [63:0] acc_wdata = '0;
    logic [63:0] rd_data;
    logic        acc_err;

    ctlreg_file #(.NUM_WIN(NUM_WIN), .MAX_TL(MAX_TL), .MAX_GL(MAX_GL)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
        .acc_idx(acc_idx), .acc_wdata(acc_wdata),
        .rd_data(rd_data), .acc_err(acc_err)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [63:0] m_pstate, m_tbase, m_hpriv, m_strand, m_tick;
    int          m_tl;
    logic [63:0] m_scr [8];
    logic [63:0] m_stk [MAX_TL][5];

    function automatic void model_reset();
        m_pstate = 0; m_tbase = 0; m_tl = 0;
        m_hpriv  = 64'h800; m_strand = 64'h50000; m_tick = 64'h8000_0000_0000_0000;
        for (int i = 0; i < 8; i++) m_scr[i] = 0;
        for (int l = 0; l < MAX_TL; l++)
            for (int r = 0; r < 5; r++) m_stk[l][r] = 0;
    endfunction

    function automatic bit exp_err(input logic we, input logic [4:0] idx);
        if (idx <= 5'h04) return (m_tl == 0);
        if (idx == 5'h0B) return we;
        if (idx >= 5'h0C && idx <= 5'h0F) return 1'b1;
        if (idx >= 5'h18) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [63:0] exp_rd(input logic [4:0] idx);
        if (idx <= 5'h04) return (m_tl == 0) ? 64'd0 : m_stk[m_tl-1][idx];
        if (idx >= 5'h10 && idx <= 5'h17) return m_scr[idx[2:0]];
        case (idx)
            5'h05: return m_pstate;
            5'h06: return 64'(m_tl);
            5'h07: return m_tbase;
            5'h08: return m_hpriv;
            5'h09: return m_strand;
            5'h0A: return m_tick;
            5'h0B: return {40'd0, 8'(MAX_GL), 8'(MAX_TL), 8'(NUM_WIN)};
            default: return 64'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [4:0] idx);
        if (idx <= 5'h04) return (m_tl == 0) ? "R6" : "R5";
        if (idx >= 5'h10 && idx <= 5'h17) return "R8";
        case (idx)
            5'h05: return "R2";
            5'h06: return "R7";
            5'h07: return "R3";
            5'h08, 5'h09, 5'h0A: return "R11";
            5'h0B: return "R4";
            default: return "R9";
        endcase
    endfunction

    function automatic void model_write(input logic [4:0] idx, input logic [63:0] d);
        if (idx <= 5'h04) m_stk[m_tl-1][idx] = d;
        else if (idx >= 5'h10 && idx <= 5'h17) m_scr[idx[2:0]] = d;
        else case (idx)
            5'h05: m_pstate = d & 64'h13DE;
            5'h06: m_tl = (d > 64'(MAX_TL)) ? MAX_TL : int'(d);
            5'h07: m_tbase = d & ~64'h7FFF;
            5'h08: m_hpriv = d;
            5'h09: m_strand = d;
            5'h0A: m_tick = d;
            default: ;
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic en, input logic we, input logic [4:0] idx,
                       input logic [63:0] d, input string tag);
        bit e;
        string t;
        @(negedge clk);
        acc_en = en; acc_we = we; acc_idx = idx; acc_wdata = d;
        #1;
        t = (tag == "") ? tag_of(idx) : tag;
        e = en && exp_err(we, idx);
        if (en) check(t, rd_data, exp_rd(idx));
        check((en ? t : "R10"), 64'(acc_err), 64'(e));
        @(posedge clk);
        if (en && we && !e) model_write(idx, d);
        #1;
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values across every index, trap level zero
        for (int i = 0; i < 32; i++) acc(1'b1, 1'b0, 5'(i), 64'd0, "R1");
        for (int l = 1; l <= MAX_TL; l++) begin
            acc(1'b1, 1'b1, 5'h06, 64'(l), "R7");
            for (int r = 0; r < 5; r++) acc(1'b1, 1'b0, 5'(r), 64'd0, "R1");
        end

        // R10: no access strobe means no write and no error
        acc(1'b0, 1'b1, 5'h06, 64'd2, "R10");
        acc(1'b1, 1'b0, 5'h06, 64'd0, "R10");
        acc(1'b0, 1'b1, 5'h1F, 64'd0, "R10");

        // R5: banking per level
        acc(1'b1, 1'b1, 5'h06, 64'd1, "R7");
        acc(1'b1, 1'b1, 5'h00, 64'h1111, "R5");
        acc(1'b1, 1'b1, 5'h04, 64'hAAAA, "R5");
        acc(1'b1, 1'b1, 5'h06, 64'd2, "R7");
        acc(1'b1, 1'b0, 5'h00, 64'd0, "R5");
        acc(1'b1, 1'b1, 5'h00, 64'h2222, "R5");
        acc(1'b1, 1'b1, 5'h06, 64'd1, "R7");
        acc(1'b1, 1'b0, 5'h00, 64'd0, "R5");
        acc(1'b1, 1'b0, 5'h04, 64'd0, "R5");

        // R7: saturation
        acc(1'b1, 1'b1, 5'h06, 64'd15, "R7");
        acc(1'b1, 1'b0, 5'h06, 64'd0, "R7");
        acc(1'b1, 1'b1, 5'h06, 64'hFFFF_FFFF_FFFF_FFFF, "R7");
        acc(1'b1, 1'b0, 5'h06, 64'd0, "R7");

        // R6: level zero bank access discarded
        acc(1'b1, 1'b1, 5'h06, 64'd0, "R7");
        acc(1'b1, 1'b1, 5'h00, 64'hDEAD, "R6");
        acc(1'b1, 1'b1, 5'h06, 64'd1, "R7");
        acc(1'b1, 1'b0, 5'h00, 64'd0, "R6");

        // R2, R3: masks with all-ones data
        acc(1'b1, 1'b1, 5'h05, 64'hFFFF_FFFF_FFFF_FFFF, "R2");
        acc(1'b1, 1'b0, 5'h05, 64'd0, "R2");
        acc(1'b1, 1'b1, 5'h07, 64'hFFFF_FFFF_FFFF_FFFF, "R3");
        acc(1'b1, 1'b0, 5'h07, 64'd0, "R3");

        // R4, R9: flagged writes change nothing
        acc(1'b1, 1'b1, 5'h0B, 64'd0, "R4");
        acc(1'b1, 1'b0, 5'h0B, 64'd0, "R4");
        acc(1'b1, 1'b1, 5'h0C, 64'h55, "R9");
        acc(1'b1, 1'b1, 5'h1A, 64'h55, "R9");
        acc(1'b1, 1'b0, 5'h06, 64'd0, "R9");
        acc(1'b1, 1'b0, 5'h05, 64'd0, "R9");

        // R8: scratchpad independence
        for (int i = 0; i < 8; i++) acc(1'b1, 1'b1, 5'(16 + i), 64'h100 * (i + 1), "R8");
        for (int i = 0; i < 8; i++) acc(1'b1, 1'b0, 5'(16 + i), 64'd0, "R8");

        // R11: plain registers
        acc(1'b1, 1'b1, 5'h0A, 64'h1234, "R11");
        acc(1'b1, 1'b0, 5'h0A, 64'd0, "R11");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [4:0]  ix;
            logic [63:0] d;
            ix = ($urandom_range(0, 3) == 0) ? 5'h06 : 5'($urandom_range(0, 31));
            d  = (ix == 5'h06) ? 64'($urandom_range(0, 9)) : rnd64();
            acc(1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 1)), ix, d, "");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule